// File: doc/BRIEF.md
# Flash Image Checksum Calculator

This block produces the 16-bit verification checksum of a programmed flash image. It reads the image itself through a simple memory read port with a fixed latency. After a start pulse it first fetches the two configuration words and the four user-ID words. It then decides, from the code-protection bit in the first configuration word, which of two sums to form.

In unprotected mode every program word from address 0 up to the last implemented word is added with a 16-bit wrap. The masked configuration words are added to that. In protected mode program memory is not read at all. The checksum is then the masked configuration words plus one 16-bit word built from the low nibbles of the four user IDs. The program size is chosen at run time from three sizes: one, two or four times a base size, with a base of 2K words by default. The result is presented with a one-cycle done pulse and stays on the output until the next run starts.

Top module: `img_csum_engine`

## Requirements
- R1: While reset is asserted and right after it, `done_o` and `rd_req_o` are 0 and `checksum_o` is 0000h.
- R2: A start accepted while idle issues six reads on consecutive cycles, in this order: 2007h, 2008h, 2000h, 2001h, 2002h, 2003h.
- R3: When bit 6 of the word read at 2007h is 0 (protected), no read below 2000h is issued.
- R4: When bit 6 of the word at 2007h is 1, program addresses 0 up to N-1 are each read exactly once, in ascending order and on consecutive cycles. N is UNIT_WORDS for `size_sel_i`=0, 2*UNIT_WORDS for 1, and 4*UNIT_WORDS for 2 or 3.
- R5: In unprotected mode the checksum is (sum of the N program words + (w2007 & mask1) + (w2008 & mask2)) mod 2^16. With blank 3FFFh words, 8K words, w2007=2AC3h, w2008=3FEFh, mask1=377Fh and mask2=0030h, the result is 0263h.
- R6: Only the bits set in `mask1_i` and `mask2_i` contribute the configuration words to the checksum. A zero mask removes that word from the checksum.
- R7: In protected mode the checksum is (w2007&mask1) + (w2008&mask2) + ((id0&Fh)<<12 | (id1&Fh)<<8 | (id2&Fh)<<4 | (id3&Fh)), mod 2^16. The IDs are the words at 2000h..2003h. With w2007=2A83h, w2008=3FEFh and IDs 0123h, 4567h, 89ABh and CDEFh, the result is 59E2h.
- R8: `done_o` is high for exactly one cycle per run. `checksum_o` holds its value from that cycle until the next accepted start.
- R9: A start pulse that arrives while a run is in progress is ignored: the checksum and the number of program reads are the same as without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (accepted only when idle) |
| size_sel_i | input | 2 | Program size select: 0 = 1x, 1 = 2x, 2 or 3 = 4x UNIT_WORDS |
| mask1_i | input | DATA_W | Mask applied to the word at 2007h |
| mask2_i | input | DATA_W | Mask applied to the word at 2008h |
| rd_req_o | output | 1 | Read request, one word per cycle |
| rd_addr_o | output | ADDR_W | Read address |
| rd_data_i | input | DATA_W | Read data, valid RD_LAT cycles after the request |
| done_o | output | 1 | One-cycle pulse when the checksum is ready |
| checksum_o | output | SUM_W | Checksum result |

## Verification
The accumulator takes in returning program words while the sequencer is still issuing new requests. A second start pulse can land in that same window. The bench provokes this by pulsing start 30 cycles into a 4K-word run, while reads and returns are both in flight. It judges the run by comparing the final checksum and the program read count with values computed arithmetically in the bench. The two published reference images are run to their exact results, and the mask and size encodings are swept in both modes.

// File: rtl/csum_pkg.sv
package csum_pkg;

   // Origin of a returning read word
   typedef enum logic [1:0] {
      K_CFG1 = 2'd0,
      K_CFG2 = 2'd1,
      K_UID  = 2'd2,
      K_PROG = 2'd3
   } src_kind_e;

   typedef struct packed {
      logic      vld;
      src_kind_e kind;
      logic [1:0] slot;
   } rd_tag_t;

   localparam int unsigned UID_COUNT = 4;
   localparam int unsigned NIB_W     = 4;

endpackage

// File: rtl/csum_seq.sv
module csum_seq
   import csum_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int CNT_W  = 14,
   parameter logic [ADDR_W-1:0] UID_ADDR  = 14'h2000,
   parameter logic [ADDR_W-1:0] CFG1_ADDR = 14'h2007,
   parameter logic [ADDR_W-1:0] CFG2_ADDR = 14'h2008
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  n_words_i,
   input  logic              pipe_busy_i,
   input  logic              prot_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output rd_tag_t           tag_o,
   output logic              clear_o,
   output logic              idle_o,
   output logic              fin_o
);

   localparam int HDR_N  = 2 + UID_COUNT;
   localparam int STEP_W = $clog2(HDR_N);

   typedef enum logic [2:0] {
      S_IDLE, S_HDR, S_WAITH, S_PROG, S_DRAIN, S_FIN
   } st_e;

   st_e               st_q;
   logic [STEP_W-1:0] step_q;
   logic [CNT_W-1:0]  pcnt_q;
   logic [STEP_W-1:0] uid_ofs;

   assign uid_ofs = step_q - STEP_W'(2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         step_q <= '0;
         pcnt_q <= '0;
      end else begin
         case (st_q)
            S_IDLE: begin
               if (start_i) begin
                  st_q   <= S_HDR;
                  step_q <= '0;
               end
            end
            S_HDR: begin
               step_q <= step_q + 1'b1;
               if (step_q == STEP_W'(HDR_N - 1)) st_q <= S_WAITH;
            end
            S_WAITH: begin
               if (!pipe_busy_i) begin
                  pcnt_q <= '0;
                  st_q   <= prot_i ? S_FIN : S_PROG;
               end
            end
            S_PROG: begin
               pcnt_q <= pcnt_q + 1'b1;
               if (pcnt_q == n_words_i - 1'b1) st_q <= S_DRAIN;
            end
            S_DRAIN: begin
               if (!pipe_busy_i) st_q <= S_FIN;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      rd_req_o  = 1'b0;
      rd_addr_o = '0;
      tag_o     = '0;
      if (st_q == S_HDR) begin
         rd_req_o = 1'b1;
         case (step_q)
            STEP_W'(0): begin
               rd_addr_o  = CFG1_ADDR;
               tag_o.kind = K_CFG1;
            end
            STEP_W'(1): begin
               rd_addr_o  = CFG2_ADDR;
               tag_o.kind = K_CFG2;
            end
            default: begin
               rd_addr_o  = UID_ADDR + ADDR_W'(uid_ofs);
               tag_o.kind = K_UID;
               tag_o.slot = 2'(uid_ofs);
            end
         endcase
      end else if (st_q == S_PROG) begin
         rd_req_o   = 1'b1;
         rd_addr_o  = ADDR_W'(pcnt_q);
         tag_o.kind = K_PROG;
      end
      tag_o.vld = rd_req_o;
   end

   assign clear_o = (st_q == S_IDLE) && start_i;
   assign idle_o  = (st_q == S_IDLE);
   assign fin_o   = (st_q == S_FIN);

endmodule

// File: rtl/csum_tag_pipe.sv
module csum_tag_pipe
   import csum_pkg::*;
#(
   parameter int LAT = 2
)(
   input  logic    clk,
   input  logic    rst_n,
   input  rd_tag_t tag_i,
   output rd_tag_t tag_o,
   output logic    busy_o
);

   rd_tag_t stg_q [LAT];

   for (genvar g = 0; g < LAT; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[0] <= '0;
            else        stg_q[0] <= tag_i;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '0;
            else        stg_q[g] <= stg_q[g-1];
         end
      end
   end

   assign tag_o = stg_q[LAT-1];

   always_comb begin
      busy_o = 1'b0;
      for (int i = 0; i < LAT; i++) busy_o = busy_o | stg_q[i].vld;
   end

endmodule

// File: rtl/csum_accum.sv
module csum_accum
   import csum_pkg::*;
#(
   parameter int DATA_W   = 14,
   parameter int SUM_W    = 16,
   parameter int PROT_BIT = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  rd_tag_t           tag_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [DATA_W-1:0] mask1_i,
   input  logic [DATA_W-1:0] mask2_i,
   output logic              prot_o,
   output logic [SUM_W-1:0]  sum_o
);

   localparam int PACK_W = UID_COUNT * NIB_W;

   logic [SUM_W-1:0]  cfg1_q, cfg2_q, prog_q;
   logic              prot_q;
   logic [PACK_W-1:0] id_pack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg1_q <= '0;
         cfg2_q <= '0;
         prog_q <= '0;
         prot_q <= 1'b0;
      end else if (clear_i) begin
         cfg1_q <= '0;
         cfg2_q <= '0;
         prog_q <= '0;
         prot_q <= 1'b0;
      end else if (tag_i.vld) begin
         case (tag_i.kind)
            K_CFG1: begin
               cfg1_q <= SUM_W'(data_i & mask1_i);
               prot_q <= ~data_i[PROT_BIT];
            end
            K_CFG2: cfg2_q <= SUM_W'(data_i & mask2_i);
            K_PROG: prog_q <= prog_q + SUM_W'(data_i);
            default: ;
         endcase
      end
   end

   // One nibble register per user-ID slot; slot 0 lands in the top nibble
   for (genvar g = 0; g < UID_COUNT; g++) begin : g_uid
      logic [NIB_W-1:0] nib_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       nib_q <= '0;
         else if (clear_i) nib_q <= '0;
         else if (tag_i.vld && tag_i.kind == K_UID && tag_i.slot == 2'(g))
            nib_q <= data_i[NIB_W-1:0];
      end
      assign id_pack[(UID_COUNT-1-g)*NIB_W +: NIB_W] = nib_q;
   end

   assign prot_o = prot_q;
   assign sum_o  = cfg1_q + cfg2_q + (prot_q ? SUM_W'(id_pack) : prog_q);

endmodule

// File: rtl/img_csum_engine.sv
module img_csum_engine
   import csum_pkg::*;
#(
   parameter int ADDR_W     = 14,
   parameter int DATA_W     = 14,
   parameter int SUM_W      = 16,
   parameter int UNIT_WORDS = 2048,
   parameter int RD_LAT     = 2,
   parameter int PROT_BIT   = 6,
   parameter logic [ADDR_W-1:0] UID_ADDR  = 14'h2000,
   parameter logic [ADDR_W-1:0] CFG1_ADDR = 14'h2007,
   parameter logic [ADDR_W-1:0] CFG2_ADDR = 14'h2008
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        size_sel_i,
   input  logic [DATA_W-1:0] mask1_i,
   input  logic [DATA_W-1:0] mask2_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              done_o,
   output logic [SUM_W-1:0]  checksum_o
);

   localparam int MAX_WORDS = 4 * UNIT_WORDS;
   localparam int CNT_W     = $clog2(MAX_WORDS) + 1;

   if (RD_LAT < 1) begin : g_bad_lat
      $error("RD_LAT must be at least 1");
   end
   if ((UNIT_WORDS & (UNIT_WORDS - 1)) != 0 || UNIT_WORDS < 1) begin : g_bad_unit
      $error("UNIT_WORDS must be a power of two");
   end
   if (MAX_WORDS > int'(UID_ADDR)) begin : g_bad_span
      $error("program span overlaps the configuration area");
   end
   if (UID_COUNT * NIB_W > SUM_W || PROT_BIT >= DATA_W || DATA_W > SUM_W) begin : g_bad_w
      $error("width parameters inconsistent");
   end

   logic [CNT_W-1:0] n_words_w;
   rd_tag_t          tag_req, tag_ret;
   logic             pipe_busy, prot_w, clear_w, idle_w, fin_w;
   logic [SUM_W-1:0] sum_w;

   always_comb begin
      case (size_sel_i)
         2'd0:    n_words_w = CNT_W'(UNIT_WORDS);
         2'd1:    n_words_w = CNT_W'(2 * UNIT_WORDS);
         default: n_words_w = CNT_W'(MAX_WORDS);
      endcase
   end

   csum_seq #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W),
      .UID_ADDR(UID_ADDR), .CFG1_ADDR(CFG1_ADDR), .CFG2_ADDR(CFG2_ADDR)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .n_words_i(n_words_w),
      .pipe_busy_i(pipe_busy), .prot_i(prot_w),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .tag_o(tag_req),
      .clear_o(clear_w), .idle_o(idle_w), .fin_o(fin_w)
   );

   csum_tag_pipe #(.LAT(RD_LAT)) u_pipe (
      .clk(clk), .rst_n(rst_n), .tag_i(tag_req), .tag_o(tag_ret), .busy_o(pipe_busy)
   );

   csum_accum #(.DATA_W(DATA_W), .SUM_W(SUM_W), .PROT_BIT(PROT_BIT)) u_acc (
      .clk(clk), .rst_n(rst_n), .clear_i(clear_w), .tag_i(tag_ret),
      .data_i(rd_data_i), .mask1_i(mask1_i), .mask2_i(mask2_i),
      .prot_o(prot_w), .sum_o(sum_w)
   );

   assign done_o     = fin_w;
   assign checksum_o = sum_w;

endmodule

// File: rtl/csum_chk.sv
module csum_chk #(
   parameter int ADDR_W = 14,
   parameter int SUM_W  = 16,
   parameter int CNT_W  = 14,
   parameter logic [ADDR_W-1:0] UID_ADDR  = 14'h2000,
   parameter logic [ADDR_W-1:0] CFG1_ADDR = 14'h2007
)(
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              rd_req_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              done_o,
   input logic [SUM_W-1:0]  checksum_o,
   input logic              idle,
   input logic              prot,
   input logic [CNT_W-1:0]  n_words
);

   logic prog_rd;
   assign prog_rd = rd_req_o && (rd_addr_o < UID_ADDR);

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!done_o && !rd_req_o));

   p_hdr_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && start_i) |=> (rd_req_o && rd_addr_o == CFG1_ADDR));

   p_prot_no_prog_r3: assert property (@(posedge clk) disable iff (!rst_n)
      prog_rd |-> !prot);

   p_prog_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      prog_rd |-> (int'(rd_addr_o) < int'(n_words)));

   p_prog_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_rd && rd_addr_o != '0) |->
         ($past(rd_req_o) && rd_addr_o == $past(rd_addr_o) + 1'b1));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> $stable(checksum_o));

   p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && !done_o && start_i) |=> !idle);

endmodule

bind img_csum_engine csum_chk #(
   .ADDR_W(ADDR_W), .SUM_W(SUM_W), .CNT_W(CNT_W),
   .UID_ADDR(UID_ADDR), .CFG1_ADDR(CFG1_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_req_o(rd_req_o),
   .rd_addr_o(rd_addr_o), .done_o(done_o), .checksum_o(checksum_o),
   .idle(idle_w), .prot(prot_w), .n_words(n_words_w)
);

// File: tb/img_csum_engine_tb.sv
`timescale 1ns/1ps
module img_csum_engine_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  size_sel_i = 2'd0;
   logic [13:0] mask1_i = 14'h377F;
   logic [13:0] mask2_i = 14'h0030;
   logic        rd_req_o;
   logic [13:0] rd_addr_o;
   logic [13:0] rd_data_i;
   logic        done_o;
   logic [15:0] checksum_o;

   always #2.5 clk = ~clk;

   img_csum_engine u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_sel_i(size_sel_i),
      .mask1_i(mask1_i), .mask2_i(mask2_i), .rd_req_o(rd_req_o),
      .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .done_o(done_o),
      .checksum_o(checksum_o)
   );

   // image contents
   int          pat = 0;
   logic [13:0] w_cfg1 = 14'h3FFF, w_cfg2 = 14'h3FFF;
   logic [13:0] ids [4];

   function automatic logic [13:0] prog_word(int a);
      case (pat)
         0:       return 14'h3FFF;
         1:       return 14'((a * 37 + 5) & 16'h3FFF);
         default: return 14'((a ^ (a << 3) ^ 16'h1555) & 16'h3FFF);
      endcase
   endfunction

   function automatic logic [13:0] mem_word(logic [13:0] a);
      if (a < 14'h2000)                  return prog_word(int'(a));
      if (a >= 14'h2000 && a <= 14'h2003) return ids[a[1:0]];
      if (a == 14'h2007)                 return w_cfg1;
      if (a == 14'h2008)                 return w_cfg2;
      return 14'h0;
   endfunction

   // memory with two-cycle read latency, plus request logging
   logic [13:0] mp0 = '0, mp1 = '0;
   assign rd_data_i = mp1;

   int          req_idx = 0, prog_cnt = 0, exp_next = 0;
   bit          order_bad = 0;
   logic [13:0] hdr_log [6];

   always @(posedge clk) begin
      mp0 <= rd_req_o ? mem_word(rd_addr_o) : 14'h0;
      mp1 <= mp0;
      if (rd_req_o) begin
         if (req_idx < 6) hdr_log[req_idx] = rd_addr_o;
         req_idx = req_idx + 1;
         if (rd_addr_o < 14'h2000) begin
            if (int'(rd_addr_o) != exp_next) order_bad = 1;
            exp_next = exp_next + 1;
            prog_cnt = prog_cnt + 1;
         end
      end
   end

   int n_chk = 0, n_bad = 0;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic int words_of(logic [1:0] sz);
      return 2048 << ((sz == 2'd3) ? 2 : int'(sz));
   endfunction

   function automatic logic [15:0] expect_sum(logic [1:0] sz);
      logic [15:0] s;
      s = 16'(w_cfg1 & mask1_i) + 16'(w_cfg2 & mask2_i);
      if (w_cfg1[6] == 1'b0) begin
         s = s + {ids[0][3:0], ids[1][3:0], ids[2][3:0], ids[3][3:0]};
      end else begin
         for (int a = 0; a < words_of(sz); a++) s = s + 16'(prog_word(a));
      end
      return s;
   endfunction

   logic [15:0] last_sum;

   task automatic run_case(input logic [1:0] sz, input bit poke, input string tg);
      logic [15:0] ev;
      logic [13:0] hexp [6];
      bit hok;
      int pexp;
      hexp[0] = 14'h2007; hexp[1] = 14'h2008; hexp[2] = 14'h2000;
      hexp[3] = 14'h2001; hexp[4] = 14'h2002; hexp[5] = 14'h2003;
      @(negedge clk);
      req_idx = 0; prog_cnt = 0; exp_next = 0; order_bad = 0;
      size_sel_i = sz;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (poke) begin
         repeat (30) @(negedge clk);
         start_i = 1'b1;               // R9: start while busy
         @(negedge clk);
         start_i = 1'b0;
      end
      while (!done_o) @(negedge clk);
      ev = expect_sum(sz);
      last_sum = checksum_o;
      chk(checksum_o == ev, {tg, " R5/R6/R7 checksum"}, checksum_o, ev);
      hok = 1;
      for (int i = 0; i < 6; i++) if (hdr_log[i] != hexp[i]) hok = 0;
      chk(hok, {tg, " R2 header order"}, hdr_log[0], hexp[0]);
      pexp = (w_cfg1[6] == 1'b0) ? 0 : words_of(sz);
      chk(prog_cnt == pexp, {tg, " R3/R4 program reads"}, prog_cnt, pexp);
      chk(!order_bad, {tg, " R4 ascending order"}, order_bad, 0);
      if (poke) chk(prog_cnt == pexp && checksum_o == ev, {tg, " R9 ignored start"}, prog_cnt, pexp);
      repeat (3) @(negedge clk);
      chk(!done_o, {tg, " R8 done single pulse"}, done_o, 0);
      chk(checksum_o == last_sum, {tg, " R8 checksum held"}, checksum_o, last_sum);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      ids[0] = 14'h0123; ids[1] = 14'h0567; ids[2] = 14'h09AB; ids[3] = 14'h0DEF;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!done_o && !rd_req_o && checksum_o == 16'h0, "R1 reset outputs", checksum_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done_o && !rd_req_o && checksum_o == 16'h0, "R1 after reset", checksum_o, 0);

      // R5 reference image, 8K blank, unprotected
      pat = 0; w_cfg1 = 14'h2AC3; w_cfg2 = 14'h3FEF; mask1_i = 14'h377F; mask2_i = 14'h0030;
      run_case(2'd2, 0, "ref-unprot");
      chk(last_sum == 16'h0263, "R5 reference 0263h", last_sum, 16'h0263);
      run_case(2'd3, 0, "size3");
      chk(last_sum == 16'h0263, "R4 size code 3 equals 8K", last_sum, 16'h0263);

      // R7 reference, protected
      ids[0] = 14'h0123; ids[1] = 14'h0567; ids[2] = 14'h09AB; ids[3] = 14'h0DEF;
      w_cfg1 = 14'h2A83;
      run_case(2'd2, 0, "ref-prot");
      chk(last_sum == 16'h59E2, "R7 reference 59E2h", last_sum, 16'h59E2);

      // sweeps: sizes, patterns, masks
      pat = 1; w_cfg1 = 14'h3FFF; w_cfg2 = 14'h1234; mask1_i = 14'h3FFF; mask2_i = 14'h3FFF;
      for (int s = 0; s < 3; s++) run_case(2'(s), 0, "pat1");
      pat = 2; mask1_i = 14'h0000; mask2_i = 14'h0000;   // R6: masks remove config words
      run_case(2'd0, 0, "pat2-nomask");
      mask1_i = 14'h0F0F; mask2_i = 14'h30F0;
      run_case(2'd1, 1, "pat2-poke");

      // protected sweep over ID patterns and masks
      for (int k = 0; k < 8; k++) begin
         w_cfg1 = (k % 2 == 0) ? 14'h0000 : 14'h3FBF;
         w_cfg2 = 14'(k * 16'h0511);
         mask1_i = (k < 4) ? 14'h377F : 14'h3FFF;
         mask2_i = (k < 4) ? 14'h0030 : 14'h2AAA;
         for (int j = 0; j < 4; j++) ids[j] = 14'((k * 5 + j * 3) * 16'h0107 + 16'h0A0);
         run_case(2'(k % 4), 0, "prot-sweep");
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule